// File: doc/BRIEF.md
# Display Power-Up Initialization Sequencer

This block wakes a graphic display controller and loads its working configuration. On a start request it drives the controller's active-low reset line low for a fixed time. It releases the line, waits a settle time, and then hands a fixed script of configuration bytes to an external serial transmitter, one byte at a time, over a valid/acknowledge handshake. The transmitter owns the serial bit timing and the chip-select line. The sequencer tells it where each chip-select burst ends through a last-byte flag.

A busy output drives a test indicator while the run is in progress. A done output rises when the final byte has been accepted and stays high, so that drawing logic knows it may start. A later start request repeats the whole run, from the reset pulse onward.

Top module: `disp_init_seq`

## Requirements
- R1: After rst_ni is released, and before any start request, disp_rst_no is 1, tx_valid_o is 0, tx_dc_o is 0, busy_o is 0 and done_o is 0.
- R2: A start_i pulse seen at a clock edge while not busy drives disp_rst_no low from the next cycle on. It stays low for exactly RST_CYCLES = (CLK_HZ/1000000)*RST_US cycles, which is 2000 with the defaults.
- R3: No byte is offered while disp_rst_no is low. tx_valid_o first goes high exactly WAIT_CYCLES = (CLK_HZ/1000000)*SETTLE_US cycles after disp_rst_no returns high.
- R4: The bytes are offered in the order 0xA2, 0xA0, 0xC8, 0x25, 0xA6, 0x2F, 0xAF, 0x81, 0x20. Every byte has tx_dc_o = 0, which means command.
- R5: tx_last_o is 1 on every byte except 0x81. Each single-byte command therefore closes its own chip-select burst, and 0x81 with 0x20 shares one burst.
- R6: An offered byte and its tx_last_o stay stable, with tx_valid_o high, until a clock edge sees tx_ack_i high. The next byte is offered in the following cycle.
- R7: busy_o is high from the cycle after the accepted start until the final byte is accepted. In the cycle after that acceptance, busy_o is 0 and done_o is 1. The two are never high together.
- R8: done_o stays high until the next start request. That request clears done_o and repeats the entire sequence, giving identical bytes and timing.
- R9: A start_i pulse while busy_o is high has no effect. The run gives a single reset pulse and exactly nine bytes in the order of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to run the initialization |
| tx_ack_i | input | 1 | Transmitter has taken the offered byte |
| disp_rst_no | output | 1 | Display controller reset, active low |
| tx_valid_o | output | 1 | A byte is offered to the transmitter |
| tx_data_o | output | 8 | Offered byte |
| tx_dc_o | output | 1 | Data/command select for the byte, 0 = command |
| tx_last_o | output | 1 | Byte closes the current chip-select burst |
| busy_o | output | 1 | Initialization in progress (test indicator) |
| done_o | output | 1 | Initialization complete |

## Verification
A script index that skips or repeats shows at the ports at once as a wrong byte or a wrong byte count in the captured stream. A wrong burst flag shows at the handshake of the affected byte. A timer limit that is off by one changes the measured reset-low width, or the gap before the first valid, by exactly one cycle. A state machine that leaves its states at the wrong time shows up as a busy/done edge one cycle late, as a second reset pulse after a start during a run, or as a rerun that differs from the first. The transmitter model stalls acknowledge by different amounts so that hold stability is exercised.

// File: rtl/disp_init_pkg.sv
package disp_init_pkg;

  localparam int unsigned SCRIPT_LEN = 9;

  typedef struct packed {
    logic [7:0] data;
    logic       dc;
    logic       last;
  } script_ent_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RST,
    S_SETTLE,
    S_SEND,
    S_DONE
  } seq_state_e;

  function automatic script_ent_t script_at(input int unsigned idx);
    script_ent_t e;
    e.dc   = 1'b0;
    e.last = 1'b1;
    case (idx)
      0: e.data = 8'hA2;
      1: e.data = 8'hA0;
      2: e.data = 8'hC8;
      3: e.data = 8'h25;
      4: e.data = 8'hA6;
      5: e.data = 8'h2F;
      6: e.data = 8'hAF;
      7: begin e.data = 8'h81; e.last = 1'b0; end
      8: e.data = 8'h20;
      default: e.data = 8'h00;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] limit_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == limit_i - W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || expire_o) cnt_q <= '0;
    else                         cnt_q <= cnt_q + W'(1);
  end

  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < limit_i));

endmodule

// File: rtl/seq_script.sv
module seq_script
  import disp_init_pkg::*;
#(
  parameter int unsigned LEN = SCRIPT_LEN,
  localparam int unsigned IW = $clog2(LEN + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        restart_i,
  input  logic        advance_i,
  output script_ent_t entry_o,
  output logic        final_o
);
  logic [IW-1:0] idx_q;

  assign entry_o = script_at(int'(idx_q));
  assign final_o = (idx_q == IW'(LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     idx_q <= '0;
    else if (restart_i)              idx_q <= '0;
    else if (advance_i && !final_o)  idx_q <= idx_q + IW'(1);
  end

  assert_idx_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q < IW'(LEN));

endmodule

// File: rtl/disp_init_seq.sv
module disp_init_seq
  import disp_init_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 200_000_000,
  parameter int unsigned RST_US    = 10,
  parameter int unsigned SETTLE_US = 10,
  localparam int unsigned RST_CYCLES  = (CLK_HZ / 1_000_000) * RST_US,
  localparam int unsigned WAIT_CYCLES = (CLK_HZ / 1_000_000) * SETTLE_US,
  localparam int unsigned MAX_CYC = (RST_CYCLES > WAIT_CYCLES) ? RST_CYCLES : WAIT_CYCLES,
  localparam int unsigned TW = $clog2(MAX_CYC + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       tx_ack_i,
  output logic       disp_rst_no,
  output logic       tx_valid_o,
  output logic [7:0] tx_data_o,
  output logic       tx_dc_o,
  output logic       tx_last_o,
  output logic       busy_o,
  output logic       done_o
);
  seq_state_e  state_q, state_d;
  logic        tmr_run, tmr_exp;
  logic [TW-1:0] tmr_limit;
  logic        accept, take, scr_final;
  script_ent_t entry;

  assign accept    = start_i && (state_q == S_IDLE || state_q == S_DONE);
  assign take      = (state_q == S_SEND) && tx_ack_i;
  assign tmr_run   = (state_q == S_RST) || (state_q == S_SETTLE);
  assign tmr_limit = (state_q == S_RST) ? TW'(RST_CYCLES) : TW'(WAIT_CYCLES);

  seq_timer #(.W(TW)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (tmr_run),
    .limit_i  (tmr_limit),
    .expire_o (tmr_exp)
  );

  seq_script #(.LEN(SCRIPT_LEN)) i_script (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (accept),
    .advance_i (take),
    .entry_o   (entry),
    .final_o   (scr_final)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE, S_DONE: if (accept) state_d = S_RST;
      S_RST:          if (tmr_exp) state_d = S_SETTLE;
      S_SETTLE:       if (tmr_exp) state_d = S_SEND;
      S_SEND:         if (take && scr_final) state_d = S_DONE;
      default:        state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  assign disp_rst_no = (state_q != S_RST);
  assign tx_valid_o  = (state_q == S_SEND);
  assign tx_data_o   = tx_valid_o ? entry.data : 8'h00;
  assign tx_dc_o     = tx_valid_o ? entry.dc : 1'b0;
  assign tx_last_o   = tx_valid_o ? entry.last : 1'b0;
  assign busy_o      = tmr_run || tx_valid_o;
  assign done_o      = (state_q == S_DONE);

  assert_start_pulls_rst_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> !disp_rst_no);

  assert_no_tx_in_reset_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !disp_rst_no |-> !tx_valid_o);

  assert_hold_until_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ack_i) |=> (tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o)));

  assert_busy_done_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  assert_done_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  assert_start_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && disp_rst_no) |=> disp_rst_no);

endmodule

// File: tb/test_disp_init_seq.sv
`timescale 1ns/1ps
module test_disp_init_seq;
  localparam int RST_CYC  = 2000;
  localparam int WAIT_CYC = 2000;

  logic clk = 0, rst_ni = 0, start_i = 0, tx_ack_i = 0;
  logic disp_rst_no, tx_valid_o, tx_dc_o, tx_last_o, busy_o, done_o;
  logic [7:0] tx_data_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  disp_init_seq i_disp_init_seq (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .tx_ack_i(tx_ack_i),
    .disp_rst_no(disp_rst_no), .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o),
    .tx_dc_o(tx_dc_o), .tx_last_o(tx_last_o), .busy_o(busy_o), .done_o(done_o));

  // transmitter model and port monitor
  int ack_delay = 0, wcnt = 0;
  logic [7:0] log_data [0:31];
  logic       log_last [0:31];
  logic       log_dc   [0:31];
  int nbytes = 0, low_cnt = 0, low_pulses = 0, gap = 0, gap_res = -1, hold_bad = 0;
  bit gapping = 0, prev_rst = 1, holding = 0;
  logic [7:0] held;

  always @(negedge clk) begin
    if (!disp_rst_no) begin
      low_cnt++;
      if (prev_rst) low_pulses++;
      gapping = 1; gap = 0;
    end else if (gapping) begin
      if (tx_valid_o) begin gap_res = gap; gapping = 0; end
      else gap++;
    end
    prev_rst = disp_rst_no;

    if (tx_ack_i) begin
      tx_ack_i = 0;
      holding = 0;
    end else if (tx_valid_o) begin
      if (holding && tx_data_o != held) hold_bad++;
      if (!holding) begin held = tx_data_o; holding = 1; end
      if (wcnt >= ack_delay) begin
        if (nbytes < 32) begin
          log_data[nbytes] = tx_data_o;
          log_last[nbytes] = tx_last_o;
          log_dc[nbytes]   = tx_dc_o;
        end
        nbytes++;
        tx_ack_i = 1;
        wcnt = 0;
      end else wcnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int i);
    case (i)
      0: return 8'hA2; 1: return 8'hA0; 2: return 8'hC8; 3: return 8'h25;
      4: return 8'hA6; 5: return 8'h2F; 6: return 8'hAF; 7: return 8'h81;
      default: return 8'h20;
    endcase
  endfunction

  task automatic clear_log();
    nbytes = 0; low_cnt = 0; low_pulses = 0; gap_res = -1; hold_bad = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (nbytes < 9 && n < 50000) begin @(posedge clk); #1; n++; end
    chk(busy_o == 0, "R7 busy low after final ack", busy_o, 0);
    chk(done_o == 1, "R7 done high after final ack", done_o, 1);
  endtask

  task automatic check_stream(input string tag);
    chk(nbytes == 9, {tag, " byte count"}, nbytes, 9);
    for (int i = 0; i < 9; i++) begin
      chk(log_data[i] == exp_byte(i), "R4 byte order", log_data[i], exp_byte(i));
      chk(log_dc[i] == 0, "R4 dc is command", log_dc[i], 0);
      chk(log_last[i] == (i != 7), "R5 burst last flag", log_last[i], (i != 7));
    end
    chk(low_cnt == RST_CYC, "R2 reset low width", low_cnt, RST_CYC);
    chk(low_pulses == 1, {tag, " single reset pulse"}, low_pulses, 1);
    chk(gap_res == WAIT_CYC, "R3 settle gap", gap_res, WAIT_CYC);
    chk(hold_bad == 0, "R6 byte stable until ack", hold_bad, 0);
  endtask

  task automatic t_reset();
    #1;
    chk(disp_rst_no == 1, "R1 reset line idle", disp_rst_no, 1);
    chk(tx_valid_o == 0, "R1 no valid", tx_valid_o, 0);
    chk(tx_dc_o == 0, "R1 dc low", tx_dc_o, 0);
    chk(busy_o == 0, "R1 busy low", busy_o, 0);
    chk(done_o == 0, "R1 done low", done_o, 0);
  endtask

  task automatic t_run(input int dly, input string tag);
    ack_delay = dly;
    clear_log();
    pulse_start();
    #1;
    chk(disp_rst_no == 0, "R2 reset asserted after start", disp_rst_no, 1'b0);
    chk(busy_o == 1, "R7 busy after start", busy_o, 1);
    chk(done_o == 0, "R8 done cleared by start", done_o, 0);
    wait_done();
    check_stream(tag);
    repeat (40) @(negedge clk);
    chk(done_o == 1, "R8 done held", done_o, 1);
    chk(tx_valid_o == 0 && disp_rst_no == 1, "R8 quiet when done", tx_valid_o, 0);
  endtask

  task automatic t_ignore_start();
    ack_delay = 2;
    clear_log();
    pulse_start();
    repeat (100) @(negedge clk);
    start_i = 1; @(negedge clk); start_i = 0;
    while (nbytes < 3) @(negedge clk);
    start_i = 1; @(negedge clk); start_i = 0;
    wait_done();
    check_stream("R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    repeat (5) @(negedge clk);
    t_reset();
    t_run(0, "R4 zero-stall");
    t_run(3, "R8 rerun stalled");
    t_ignore_start();
    t_run(1, "R8 rerun");
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule